// File: doc/BRIEF.md
# Command-Driven UART Transmitter

This block sends bytes on an asynchronous serial line, but only while software has a transmit command running. Software sets a character count, loads bytes into a small transmit queue, and writes a start opcode to the command register. The engine then takes bytes from the queue one at a time and sends each as a frame of one start bit, eight data bits (least significant first) and one stop bit. Each bit lasts 32 ticks of a divided serial clock.

While a command runs, the engine raises a queue-low flag whenever the queue fill is at or below a programmable level, so software knows to add more bytes. When the last stop bit of the programmed count has gone out, the engine raises a done flag and returns to idle. A write to the control register cancels a running command at once and raises an abort flag. All three flags are sticky, can be cleared by writing a 1 to the same position, and together drive a single interrupt line.

Top module: `uart_cmd_tx`

## Requirements
- R1: After reset, the serial line is high, the status register (0x08) reads 0, the flag register (0x0C) reads 0, the level register (0x18) reads 2, the clock register (0x1C) reads 0 and the queue count register (0x24) reads 0.
- R2: A write to the command register (0x00) whose bits 31:27 equal 1 starts a command when idle, and status bit 0 then reads 1. Other opcodes, and start writes while a command runs, have no effect.
- R3: Each frame is a low start bit, eight data bits least significant first, then a high stop bit. Each bit lasts 32 × max(div,1) clock cycles, where div is bits 15:4 of the clock register. While clock register bit 0 is low, the line holds its current level. The line is high between frames.
- R4: A command sends exactly the count written to the length register (0x14), taking bytes from the queue in write order. If the queue is empty, the line stays high and the command stays active until data arrives.
- R5: Flag bit 0 (done) sets one cycle after the final stop bit ends, and status bit 0 clears at the same time. With a count of 0, done sets on the second cycle after the start write.
- R6: Flag bit 30 (queue low) sets on any cycle in which a command is active and the queue count is at or below the level register value.
- R7: Writing the control register (0x04) with bit 1 set while a command runs returns the line high on the next cycle, clears status bit 0 and sets flag bit 5 (abort). Bytes not yet taken stay in the queue. The same write while idle changes nothing.
- R8: Writing the clear register (0x10) clears each flag whose bit is 1 in the written value. If a flag's set condition holds in the same cycle, the flag stays set.
- R9: The interrupt output is high exactly when at least one of the three flags is set.
- R10: A write to the data register (0x20) adds bits 7:0 to the queue (8 entries). When the queue is full, the write is dropped. The queue count register reports the number of stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| tx_o | output | 1 | Serial output line, idle high |
| irq_o | output | 1 | Interrupt, OR of the sticky flags |

## Verification
The transmit path is tried with several byte patterns:
- Bit patterns such as 0xA5, 0x3C, 0xFF and 0x00 expose bit-order or framing slips.
- Multi-byte commands show the count and the gap between frames.
- A command started on an empty queue shows the engine waits rather than sending garbage.
- A divider of 3 against 1 separates the prescaler from the 32-tick bit counter.
- Pausing the serial clock mid-frame checks that the line holds its level.

Aborting mid-frame, and then restarting to drain the leftover bytes, shows whether the queue keeps what was not sent. Overfilling the queue and clearing flags while their set condition still holds probe the edges of the queue and of the flag logic.

// File: rtl/ucmd_pkg.sv
package ucmd_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_CMD    = 6'h00;
    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h04;
    localparam logic [ADDR_W-1:0] A_STATUS = 6'h08;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 6'h0C;
    localparam logic [ADDR_W-1:0] A_FCLR   = 6'h10;
    localparam logic [ADDR_W-1:0] A_LEN    = 6'h14;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 6'h18;
    localparam logic [ADDR_W-1:0] A_CLKCFG = 6'h1C;
    localparam logic [ADDR_W-1:0] A_DATA   = 6'h20;
    localparam logic [ADDR_W-1:0] A_COUNT  = 6'h24;

    localparam logic [4:0] OP_SEND = 5'd1;
    localparam int OP_LSB    = 27;
    localparam int KILL_BIT  = 1;
    localparam int F_DONE    = 0;
    localparam int F_ABORT   = 5;
    localparam int F_LOW     = 30;
    localparam int CDIV_W    = 12;
    localparam int CDIV_LSB  = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_SEND
    } seq_state_e;

    typedef struct packed {
        logic              en;
        logic [CDIV_W-1:0] div;
    } clk_cfg_t;

    typedef struct packed {
        logic low;
        logic abort;
        logic done;
    } flags_t;

    function automatic logic [CDIV_W-1:0] div_last(input logic [CDIV_W-1:0] d);
        return (d == '0) ? '0 : d - 1'b1;
    endfunction

endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign do_push = push && (count != FULL);
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4: the sequencer never takes a byte that is not there
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

    // R10: a push into a full queue with no pop leaves it full
    assert_full_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && count == FULL) |=> (count == FULL));

endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
    import ucmd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TICKS  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kill,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              tick_en,
    input  logic [CDIV_W-1:0] div,
    output logic              txd,
    output logic              busy,
    output logic              frame_end
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int SW      = $clog2(TICKS);
    localparam int BW      = $clog2(FRAME_W);

    logic [FRAME_W-1:0] frame;
    logic [BW-1:0]      bitn;
    logic [CDIV_W-1:0]  pre;
    logic [SW-1:0]      samp;
    logic               pre_wrap, samp_wrap, last_bit;

    assign pre_wrap  = (pre >= div_last(div));
    assign samp_wrap = (samp == SW'(TICKS - 1));
    assign last_bit  = (bitn == BW'(FRAME_W - 1));
    assign frame_end = busy && tick_en && pre_wrap && samp_wrap && last_bit;
    assign txd       = busy ? frame[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            busy  <= 1'b0;
            frame <= '1;
            bitn  <= '0;
            pre   <= '0;
            samp  <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            frame <= {1'b1, data, 1'b0};
            bitn  <= '0;
            pre   <= '0;
            samp  <= '0;
        end else if (busy && tick_en) begin
            if (pre_wrap) begin
                pre <= '0;
                if (samp_wrap) begin
                    samp  <= '0;
                    frame <= {1'b1, frame[FRAME_W-1:1]};
                    if (last_bit) busy <= 1'b0;
                    else          bitn <= bitn + 1'b1;
                end else begin
                    samp <= samp + 1'b1;
                end
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    // R3: every frame opens with a low start bit
    assert_start_low_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    // R3: a paused serial clock freezes the line
    assert_pause_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick_en && !kill && !load) |=> $stable(txd));

endmodule

// File: rtl/uart_cmd_tx.sv
module uart_cmd_tx
    import ucmd_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int LEN_W      = 27,
    parameter int LEVEL_DEF  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tx_o,
    output logic              irq_o
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    seq_state_e       state;
    logic [LEN_W-1:0] len_q, rem_q;
    logic [CW-1:0]    level_q, q_count;
    clk_cfg_t         cfg_q;
    flags_t           flags_q, flags_set, flags_clr;
    logic [7:0]       q_data;
    logic             start, kill, pop, finish, push;
    logic             sh_busy, sh_end;

    assign start = reg_we && reg_addr == A_CMD && reg_wdata[31:OP_LSB] == OP_SEND
                   && state == SEQ_IDLE;
    assign kill  = reg_we && reg_addr == A_CTRL && reg_wdata[KILL_BIT]
                   && state != SEQ_IDLE;
    assign pop    = !kill && state == SEQ_LOAD && rem_q != '0 && q_count != '0;
    assign finish = !kill && state == SEQ_LOAD && rem_q == '0;
    assign push   = reg_we && reg_addr == A_DATA;

    txq_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .CW(CW)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .din(reg_wdata[7:0]),
        .pop(pop), .dout(q_data), .count(q_count)
    );

    tx_frame_shifter #(.DATA_W(8), .TICKS(32)) u_shift (
        .clk(clk), .rst(rst), .kill(kill), .load(pop), .data(q_data),
        .tick_en(cfg_q.en), .div(cfg_q.div), .txd(tx_o),
        .busy(sh_busy), .frame_end(sh_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            rem_q <= '0;
        end else if (kill) begin
            state <= SEQ_IDLE;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    state <= SEQ_LOAD;
                    rem_q <= len_q;
                end
                SEQ_LOAD: begin
                    if (finish)   state <= SEQ_IDLE;
                    else if (pop) state <= SEQ_SEND;
                end
                SEQ_SEND: if (sh_end) begin
                    rem_q <= rem_q - 1'b1;
                    state <= SEQ_LOAD;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign flags_set = '{low: (state != SEQ_IDLE && q_count <= level_q),
                         abort: kill, done: finish};
    assign flags_clr = (reg_we && reg_addr == A_FCLR)
                       ? '{low: reg_wdata[F_LOW], abort: reg_wdata[F_ABORT],
                           done: reg_wdata[F_DONE]}
                       : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            len_q   <= '0;
            level_q <= CW'(LEVEL_DEF);
            cfg_q   <= '0;
        end else begin
            flags_q <= flags_set | (flags_q & ~flags_clr);
            if (reg_we && reg_addr == A_LEN)    len_q   <= reg_wdata[LEN_W-1:0];
            if (reg_we && reg_addr == A_LEVEL)  level_q <= reg_wdata[CW-1:0];
            if (reg_we && reg_addr == A_CLKCFG) begin
                cfg_q.en  <= reg_wdata[0];
                cfg_q.div <= reg_wdata[CDIV_LSB +: CDIV_W];
            end
        end
    end

    assign irq_o = |flags_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATUS: reg_rdata[0] = (state != SEQ_IDLE);
            A_FLAGS: begin
                reg_rdata[F_DONE]  = flags_q.done;
                reg_rdata[F_ABORT] = flags_q.abort;
                reg_rdata[F_LOW]   = flags_q.low;
            end
            A_LEN:   reg_rdata[LEN_W-1:0] = len_q;
            A_LEVEL: reg_rdata[CW-1:0]    = level_q;
            A_CLKCFG: begin
                reg_rdata[0] = cfg_q.en;
                reg_rdata[CDIV_LSB +: CDIV_W] = cfg_q.div;
            end
            A_COUNT: reg_rdata[CW-1:0] = q_count;
            default: reg_rdata = '0;
        endcase
    end

    // R5: done is only raised once the shifter has let go of the line
    assert_done_after_stop_R5: assert property (@(posedge clk) disable iff (rst)
        finish |-> !sh_busy);

    // R7: an abort idles the sequencer and the line on the next cycle
    assert_abort_idle_R7: assert property (@(posedge clk) disable iff (rst)
        kill |=> (state == SEQ_IDLE && tx_o));

    // R6: the queue-low flag only rises while a command was running
    assert_low_needs_cmd_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.low) |-> $past(state != SEQ_IDLE));

    // R2: an accepted start always leads to the load phase
    assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !kill) |=> (state == SEQ_LOAD));

endmodule

// File: tb/uart_cmd_tx_tb.sv
`timescale 1ns/1ps
module uart_cmd_tx_tb;
    import ucmd_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;

    uart_cmd_tx u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_o(tx_o), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    int         m_state = 0;   // 0 idle, 1 waiting for byte, 2 sending
    int         m_rem = 0, m_cyc = 0, m_len = 0, m_lvl = 2, m_div = 0;
    bit         m_en = 0, m_done = 0, m_abort = 0, m_low = 0;
    logic [7:0] m_cur = '0;
    logic [7:0] q[$];

    function automatic int bit_time();
        return 32 * ((m_div == 0) ? 1 : m_div);
    endfunction

    function automatic logic exp_tx();
        int idx;
        if (m_state != 2) return 1'b1;
        idx = m_cyc / bit_time();
        if (idx == 0) return 1'b0;
        if (idx >= 9) return 1'b1;
        return m_cur[idx-1];
    endfunction

    function automatic logic [31:0] exp_flags();
        logic [31:0] v = '0;
        v[0] = m_done; v[5] = m_abort; v[30] = m_low;
        return v;
    endfunction

    always @(posedge clk) begin
        int qs;
        bit kill, set_done, set_low;
        logic [31:0] clr;
        if (rst) begin
            m_state = 0; m_rem = 0; m_cyc = 0; m_len = 0; m_lvl = 2; m_div = 0;
            m_en = 0; m_done = 0; m_abort = 0; m_low = 0; q.delete();
        end else begin
            qs = q.size();
            kill = reg_we && reg_addr == 6'h04 && reg_wdata[1] && m_state != 0;
            set_low = (m_state != 0) && (qs <= m_lvl);
            set_done = 0;
            if (kill) m_state = 0;
            else if (m_state == 0) begin
                if (reg_we && reg_addr == 6'h00 && reg_wdata[31:27] == 5'd1) begin
                    m_state = 1; m_rem = m_len;
                end
            end else if (m_state == 1) begin
                if (m_rem == 0) begin set_done = 1; m_state = 0; end
                else if (qs > 0) begin m_cur = q.pop_front(); m_cyc = 0; m_state = 2; end
            end else if (m_en) begin
                m_cyc++;
                if (m_cyc == 10 * bit_time()) begin m_rem--; m_state = 1; end
            end
            clr = (reg_we && reg_addr == 6'h10) ? reg_wdata : 32'h0;
            m_done  = set_done | (m_done  & !clr[0]);
            m_abort = kill     | (m_abort & !clr[5]);
            m_low   = set_low  | (m_low   & !clr[30]);
            if (reg_we && reg_addr == 6'h14) m_len = int'(reg_wdata[26:0]);
            if (reg_we && reg_addr == 6'h18) m_lvl = int'(reg_wdata[3:0]);
            if (reg_we && reg_addr == 6'h1C) begin
                m_en = reg_wdata[0]; m_div = int'(reg_wdata[15:4]);
            end
            if (reg_we && reg_addr == 6'h20 && qs < 8) q.push_back(reg_wdata[7:0]);
        end
    end

    // per-cycle comparison of the line and the interrupt
    always @(negedge clk) begin
        if (!rst) begin
            n_chk++;
            if (tx_o !== exp_tx()) begin
                n_fail++;
                $display("FAIL R3 R4 tx_o at %0t: got %b expected %b", $time, tx_o, exp_tx());
            end
            n_chk++;
            if (irq_o !== (m_done | m_abort | m_low)) begin
                n_fail++;
                $display("FAIL R9 irq_o at %0t: got %b expected %b", $time, irq_o,
                         m_done | m_abort | m_low);
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic peek(input logic [5:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s reg 0x%02h: got 0x%08h expected 0x%08h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic idle_wait();
        while (m_state != 0) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        peek(6'h08, 32'h0, "R1");
        peek(6'h0C, 32'h0, "R1");
        peek(6'h18, 32'h2, "R1");
        peek(6'h1C, 32'h0, "R1");
        peek(6'h24, 32'h0, "R1");
        n_chk++;
        if (tx_o !== 1'b1) begin n_fail++; $display("FAIL R1 tx_o: got %b expected 1", tx_o); end

        // R3 R4: three bytes, divider 1
        wr(6'h1C, 32'h11);
        wr(6'h20, 32'hA5); wr(6'h20, 32'h3C); wr(6'h20, 32'hFF);
        peek(6'h24, 32'd3, "R10");
        wr(6'h14, 32'd3);
        wr(6'h00, 32'h0800_0000);
        peek(6'h08, 32'h1, "R2");
        idle_wait();
        @(negedge clk);
        peek(6'h0C, 32'h4000_0001, "R5 R6");
        wr(6'h10, 32'h4000_0021);
        peek(6'h0C, 32'h0, "R8");

        // R2: wrong opcode ignored
        wr(6'h00, 32'h1000_0000);
        peek(6'h08, 32'h0, "R2");

        // R5: zero-length command
        wr(6'h14, 32'd0);
        wr(6'h00, 32'h0800_0000);
        @(negedge clk);
        peek(6'h0C, 32'h4000_0001, "R5");
        peek(6'h08, 32'h0, "R5");
        wr(6'h10, 32'h4000_0021);

        // R4: start on empty queue, line waits
        wr(6'h14, 32'd2);
        wr(6'h00, 32'h0800_0000);
        repeat (40) @(negedge clk);
        peek(6'h08, 32'h1, "R4");
        // R2: second start while running ignored
        wr(6'h00, 32'h0800_0000);
        wr(6'h20, 32'h00); wr(6'h20, 32'h81);
        repeat (100) @(negedge clk);
        // R8: clear while low condition still true keeps the flag
        wr(6'h10, 32'h4000_0000);
        peek(6'h0C, exp_flags(), "R8");
        idle_wait();
        @(negedge clk);
        peek(6'h0C, exp_flags(), "R5");
        wr(6'h10, 32'h4000_0021);

        // R7: abort mid-frame
        wr(6'h20, 32'h11); wr(6'h20, 32'h22); wr(6'h20, 32'h33); wr(6'h20, 32'h44);
        wr(6'h14, 32'd4);
        wr(6'h00, 32'h0800_0000);
        repeat (100) @(negedge clk);
        wr(6'h04, 32'h2);
        peek(6'h08, 32'h0, "R7");
        peek(6'h0C, exp_flags(), "R7");
        peek(6'h24, 32'd3, "R7");
        wr(6'h10, 32'h4000_0021);
        wr(6'h04, 32'h2);   // idle abort: no effect
        peek(6'h0C, 32'h0, "R7");

        // R3: drain leftovers with a pause in the middle of a frame
        wr(6'h14, 32'd3);
        wr(6'h00, 32'h0800_0000);
        repeat (150) @(negedge clk);
        wr(6'h1C, 32'h10);
        repeat (120) @(negedge clk);
        wr(6'h1C, 32'h11);
        idle_wait();
        wr(6'h10, 32'h4000_0021);

        // R3: divider 3
        wr(6'h1C, 32'h31);
        peek(6'h1C, 32'h31, "R3");
        wr(6'h20, 32'h6B);
        wr(6'h14, 32'd1);
        wr(6'h00, 32'h0800_0000);
        idle_wait();
        wr(6'h10, 32'h4000_0021);

        // R10: overfill then drain
        wr(6'h1C, 32'h11);
        for (int i = 0; i < 10; i++) wr(6'h20, 32'(8'hC0 + i));
        peek(6'h24, 32'd8, "R10");
        wr(6'h18, 32'd5);
        peek(6'h18, 32'd5, "R6");
        wr(6'h14, 32'd8);
        wr(6'h00, 32'h0800_0000);
        idle_wait();
        @(negedge clk);
        peek(6'h0C, exp_flags(), "R5 R6");
        peek(6'h24, 32'd0, "R10");
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule